// File: doc/BRIEF.md
# I2C Target Controller with Match-Source Status Word

This block answers on an I2C bus as a target device. It takes SCL and SDA inputs that are already synchronous to the system clock and watches them for START and STOP conditions. After a START it shifts in the address byte and compares the 7-bit address with three candidates: a primary own address, a second own address that can be switched on, and the general-call address, which can also be switched on. If one of them matches and acknowledging is enabled, it pulls SDA low for the acknowledge bit. It then receives bytes from the controller or sends bytes to it, depending on the direction bit.

Software sees the block through a small register port with a write strobe and a read strobe. It sets the control bits and the two own addresses there, writes the byte to send, and reads the byte received. A 32-bit status word tells software which address matched, which way the transfer runs, and how far the data movement has got. Each flag is cleared by a defined access sequence. The status word is also available directly on an output port.

Top module: `i2c_target_status`

## Requirements
- R1: After reset, every status bit is 0 and SDA is not driven (`sda_oe` = 0).
- R2: A START sets bus-busy (bit 17). A STOP clears bus-busy and transmitter (bit 18) and sets stop-detected (bit 4).
- R3: The OWN register sits at offset 1, with own address 1 in bits [6:0] and own address 2 in bits [14:8]. The address byte carries the address in bits [7:1] and the read flag in bit 0. An address equal to own address 1 sets address-matched (bit 1) and bus-busy. In the read direction it also sets transmitter (bit 18) and transmit-empty (bit 7).
- R4: When dual addressing is enabled, an address equal to own address 2 sets second-match (bit 23) and bus-busy, plus transmitter and transmit-empty in the read direction. When dual addressing is disabled, own address 2 is not acknowledged.
- R5: When general call is enabled, address 0x00 sets general-call (bit 20) and bus-busy and is acknowledged. When general call is disabled, address 0x00 is not acknowledged and bit 20 stays 0.
- R6: The CTRL register sits at offset 0: bit 0 enables acknowledge, bit 1 enables general call, bit 2 enables dual addressing. The block pulls SDA low in the acknowledge slot only for a matched address while acknowledge is enabled. A non-matching address gets no acknowledge and sets no match flag. A match while acknowledge is disabled still sets its flag but gets no acknowledge.
- R7: Each received data byte sets receive-not-empty (bit 6) while bus-busy stays set. Reading DATA at offset 2 returns that byte and clears bit 6.
- R8: Bytes are sent MSB first from the byte last written to DATA. The engine takes the byte at the start of each outgoing byte, which sets transmit-empty. A write to DATA clears transmit-empty.
- R9: Byte-transfer-finished (bit 2) sets when the controller acknowledges a sent byte while transmit-empty is set. A write to DATA clears it.
- R10: A NACK from the controller after a sent byte sets acknowledge-failure (bit 10), and the block stops driving SDA. A write to CTRL clears bit 10.
- R11: A read of STAT_LO (offset 3, returns bits 15:0) followed directly by a read of STAT_HI (offset 4, returns bits 31:16) clears address-matched, second-match and general-call.
- R12: A read of STAT_LO followed directly by a write to CTRL clears stop-detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| status | output | 32 | Live status word |

## Verification
The address comparator is driven with five patterns:
- primary write;
- second-address read;
- general call, with the feature on and then off;
- an address that matches nothing;
- a primary match with acknowledge switched off.

Together these separate which flag each source sets from whether the acknowledge bit appears on the bus. The read transfer runs three bytes. The first has its next byte refilled in time, the second has no refill, and the third is NACKed. This separates plain transmit-empty, byte-transfer-finished and acknowledge-failure. The clearing sequences are checked for both possible second accesses, so a clear that listens to the wrong access shows up.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int OWN2_SH = 8;
  localparam int OFF_CTRL = 0;
  localparam int OFF_OWN  = 1;
  localparam int OFF_DATA = 2;
  localparam int OFF_STLO = 3;
  localparam int OFF_STHI = 4;
  localparam int B_ADDR = 1;
  localparam int B_BTF  = 2;
  localparam int B_STOP = 4;
  localparam int B_RXNE = 6;
  localparam int B_TXE  = 7;
  localparam int B_AF   = 10;
  localparam int B_BUSY = 17;
  localparam int B_TRA  = 18;
  localparam int B_GC   = 20;
  localparam int B_DUAL = 23;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_HOLD, ST_ACK, ST_RX, ST_TX, ST_TACK, ST_WAIT
  } eng_st_e;
endpackage

// File: rtl/i2ct_bus_cond.sv
module i2ct_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // SDA edges while SCL is held high mark bus conditions
  assign start_o = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o  = scl_q & scl_i & ~sda_q & sda_i;
  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
endmodule

// File: rtl/i2ct_addr_cmp.sv
module i2ct_addr_cmp #(
  parameter int AW = 7
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] own1_i,
  input  logic [AW-1:0] own2_i,
  input  logic          dual_en_i,
  input  logic          gc_en_i,
  output logic          hit1_o,
  output logic          hit2_o,
  output logic          hitg_o
);
  logic is_gc;
  assign is_gc = (addr_i == '0) && gc_en_i;

  // general call wins, then primary, then second address
  always_comb begin
    hitg_o = is_gc;
    hit1_o = !is_gc && (addr_i == own1_i);
    hit2_o = !is_gc && (addr_i != own1_i) && dual_en_i && (addr_i == own2_i);
  end
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          sda_i,
  input  logic          ack_en_i,
  input  logic          gc_en_i,
  input  logic          dual_en_i,
  input  logic [AW-1:0] own1_i,
  input  logic [AW-1:0] own2_i,
  input  logic [DW-1:0] tx_byte_i,
  output logic          sda_oe,
  output logic          addr_ev,
  output logic          ev_rw,
  output logic          ev_h1,
  output logic          ev_h2,
  output logic          ev_hg,
  output logic          rx_ev,
  output logic [DW-1:0] rx_byte,
  output logic          load_ev,
  output logic          acked_ev,
  output logic          nack_ev
);
  localparam int CW = $clog2(DW);

  eng_st_e       st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic [DW-1:0] inb;
  logic          ack_drv, nxt_tx, last;
  logic          h1, h2, hg;

  assign inb  = {sh[DW-2:0], sda_i};
  assign last = (cnt == CW'(DW-1));

  i2ct_addr_cmp #(.AW(AW)) u_cmp (
    .addr_i(inb[DW-1:1]), .own1_i(own1_i), .own2_i(own2_i),
    .dual_en_i(dual_en_i), .gc_en_i(gc_en_i),
    .hit1_o(h1), .hit2_o(h2), .hitg_o(hg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; ack_drv <= 1'b0; nxt_tx <= 1'b0;
      sda_oe <= 1'b0; addr_ev <= 1'b0; ev_rw <= 1'b0; ev_h1 <= 1'b0;
      ev_h2 <= 1'b0; ev_hg <= 1'b0; rx_ev <= 1'b0; rx_byte <= '0;
      load_ev <= 1'b0; acked_ev <= 1'b0; nack_ev <= 1'b0;
    end else begin
      addr_ev <= 1'b0; rx_ev <= 1'b0; load_ev <= 1'b0;
      acked_ev <= 1'b0; nack_ev <= 1'b0;
      if (stop_i) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else if (start_i) begin
        st <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_RX: if (rise_i) begin
            sh  <= inb;
            cnt <= cnt + 1'b1;
            if (last) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                addr_ev <= 1'b1; ev_rw <= inb[0];
                ev_h1 <= h1; ev_h2 <= h2; ev_hg <= hg;
                if ((h1 | h2 | hg) && ack_en_i) begin
                  st <= ST_HOLD; ack_drv <= 1'b1; nxt_tx <= inb[0];
                end else begin
                  st <= ST_WAIT;
                end
              end else begin
                rx_ev <= 1'b1; rx_byte <= inb;
                st <= ST_HOLD; ack_drv <= ack_en_i; nxt_tx <= 1'b0;
              end
            end
          end
          ST_HOLD: if (fall_i) begin
            st <= ST_ACK; sda_oe <= ack_drv;
          end
          ST_ACK: if (fall_i) begin
            cnt <= '0;
            if (nxt_tx) begin
              st <= ST_TX; sh <= tx_byte_i; load_ev <= 1'b1;
              sda_oe <= ~tx_byte_i[DW-1];
            end else begin
              st <= ST_RX; sda_oe <= 1'b0;
            end
          end
          ST_TX: if (fall_i) begin
            if (last) begin
              st <= ST_TACK; sda_oe <= 1'b0; cnt <= '0;
            end else begin
              sh <= {sh[DW-2:0], 1'b0}; sda_oe <= ~sh[DW-2]; cnt <= cnt + 1'b1;
            end
          end
          ST_TACK: if (rise_i) begin
            if (sda_i) begin
              nack_ev <= 1'b1; st <= ST_WAIT;
            end else begin
              acked_ev <= 1'b1; st <= ST_ACK; nxt_tx <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_target_status.sv
module i2c_target_status
  import i2ct_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 7,
  parameter int RW = 32,
  parameter int OW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [OW-1:0] reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  output logic [RW-1:0] status
);
  localparam int HW = RW / 2;

  logic start, stop, rise, fall;
  logic addr_ev, ev_rw, ev_h1, ev_h2, ev_hg, rx_ev, load_ev, acked_ev, nack_ev;
  logic [DW-1:0] rx_byte, tx_buf, rx_buf;
  logic [AW-1:0] own1, own2;
  logic [2:0]    ctrl;
  logic f_addr, f_btf, f_stop, f_rxne, f_txe, f_af, f_busy, f_tra, f_gc, f_dual;
  logic lo_armed;
  logic [RW-1:0] rd_n;
  logic wr_ctrl, wr_own, wr_data, rd_lo, rd_hi, rd_data;
  logic unused_ok;

  assign unused_ok = ^reg_wdata[RW-1:OWN2_SH+AW];

  i2ct_bus_cond u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .start_o(start), .stop_o(stop), .rise_o(rise), .fall_o(fall)
  );

  i2ct_engine #(.DW(DW), .AW(AW)) u_eng (
    .clk(clk), .rst(rst), .start_i(start), .stop_i(stop), .rise_i(rise),
    .fall_i(fall), .sda_i(sda_i), .ack_en_i(ctrl[0]), .gc_en_i(ctrl[1]),
    .dual_en_i(ctrl[2]), .own1_i(own1), .own2_i(own2), .tx_byte_i(tx_buf),
    .sda_oe(sda_oe), .addr_ev(addr_ev), .ev_rw(ev_rw), .ev_h1(ev_h1),
    .ev_h2(ev_h2), .ev_hg(ev_hg), .rx_ev(rx_ev), .rx_byte(rx_byte),
    .load_ev(load_ev), .acked_ev(acked_ev), .nack_ev(nack_ev)
  );

  assign wr_ctrl = reg_wr && (reg_addr == OW'(OFF_CTRL));
  assign wr_own  = reg_wr && (reg_addr == OW'(OFF_OWN));
  assign wr_data = reg_wr && (reg_addr == OW'(OFF_DATA));
  assign rd_lo   = reg_rd && (reg_addr == OW'(OFF_STLO));
  assign rd_hi   = reg_rd && (reg_addr == OW'(OFF_STHI));
  assign rd_data = reg_rd && (reg_addr == OW'(OFF_DATA));

  always_comb begin
    status = '0;
    status[B_ADDR] = f_addr; status[B_BTF]  = f_btf;  status[B_STOP] = f_stop;
    status[B_RXNE] = f_rxne; status[B_TXE]  = f_txe;  status[B_AF]   = f_af;
    status[B_BUSY] = f_busy; status[B_TRA]  = f_tra;  status[B_GC]   = f_gc;
    status[B_DUAL] = f_dual;
  end

  always_comb begin
    rd_n = '0;
    case (int'(reg_addr))
      OFF_CTRL: rd_n[2:0] = ctrl;
      OFF_OWN: begin
        rd_n[AW-1:0] = own1;
        rd_n[OWN2_SH +: AW] = own2;
      end
      OFF_DATA: rd_n[DW-1:0] = rx_buf;
      OFF_STLO: rd_n[HW-1:0] = status[HW-1:0];
      OFF_STHI: rd_n[HW-1:0] = status[RW-1:HW];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0; own1 <= '0; own2 <= '0; tx_buf <= '0; rx_buf <= '0;
      reg_rdata <= '0; lo_armed <= 1'b0;
      f_addr <= 1'b0; f_btf <= 1'b0; f_stop <= 1'b0; f_rxne <= 1'b0; f_txe <= 1'b0;
      f_af <= 1'b0; f_busy <= 1'b0; f_tra <= 1'b0; f_gc <= 1'b0; f_dual <= 1'b0;
    end else begin
      // software side: stores and clear sequences
      if (wr_ctrl) begin
        ctrl <= reg_wdata[2:0];
        f_af <= 1'b0;
        if (lo_armed) f_stop <= 1'b0;
      end
      if (wr_own) begin
        own1 <= reg_wdata[AW-1:0];
        own2 <= reg_wdata[OWN2_SH +: AW];
      end
      if (wr_data) begin
        tx_buf <= reg_wdata[DW-1:0];
        f_txe <= 1'b0;
        f_btf <= 1'b0;
      end
      if (rd_hi && lo_armed) begin
        f_addr <= 1'b0; f_dual <= 1'b0; f_gc <= 1'b0;
      end
      if (rd_data) f_rxne <= 1'b0;
      if (reg_rd || reg_wr) lo_armed <= rd_lo;
      if (reg_rd) reg_rdata <= rd_n;
      // bus side: set events win over same-cycle clears
      if (start) begin
        f_busy <= 1'b1; f_tra <= 1'b0;
      end
      if (stop) begin
        f_busy <= 1'b0; f_tra <= 1'b0; f_stop <= 1'b1;
      end
      if (addr_ev) begin
        if (ev_hg) f_gc <= 1'b1;
        if (ev_h1) f_addr <= 1'b1;
        if (ev_h2) f_dual <= 1'b1;
        if ((ev_h1 || ev_h2) && ev_rw) begin
          f_tra <= 1'b1; f_txe <= 1'b1;
        end
      end
      if (rx_ev) begin
        f_rxne <= 1'b1; rx_buf <= rx_byte;
      end
      if (load_ev) f_txe <= 1'b1;
      if (acked_ev && f_txe) f_btf <= 1'b1;
      if (nack_ev) f_af <= 1'b1;
    end
  end
endmodule

// File: rtl/i2ct_sva.sv
module i2ct_sva #(
  parameter int RW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_i,
  input logic          sda_oe,
  input logic [RW-1:0] status
);
  AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !status[17] |-> !sda_oe); // R1
  AST_STOP_FREES_BUS: assert property (@(posedge clk) disable iff (rst)
    $rose(status[4]) |-> !status[17]); // R2
  AST_TRA_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    status[18] |-> status[17]); // R3
  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_i)); // R6
  AST_RXNE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(status[6]) |-> status[17]); // R7
  AST_BTF_IN_TX: assert property (@(posedge clk) disable iff (rst)
    $rose(status[2]) |-> status[18]); // R9
  AST_AF_RELEASED: assert property (@(posedge clk) disable iff (rst)
    $rose(status[10]) |-> !sda_oe); // R10
endmodule

bind i2c_target_status i2ct_sva #(.RW(RW)) u_sva (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe), .status(status)
);

// File: tb/sim_i2c_target_status.sv
`timescale 1ns/1ps
module sim_i2c_target_status;
  localparam int Q = 6;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, status;
  logic sda_oe, sda_bus;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  string tag_q[$];
  logic [31:0] exp_q[$];
  logic [31:0] act_q[$];

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_target_status u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .status(status)
  );

  // driver side: push expected and observed values
  task automatic push(input string tag, input logic [31:0] e, input logic [31:0] a);
    tag_q.push_back(tag); exp_q.push_back(e); act_q.push_back(a);
  endtask

  // monitor: pop and compare
  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0) begin
      string t;
      logic [31:0] e, a;
      t = tag_q.pop_front(); e = exp_q.pop_front(); a = act_q.pop_front();
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  task automatic finish_run;
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  task automatic qw; repeat (Q) @(negedge clk); endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic st(input string tag, input logic [31:0] e);
    @(negedge clk); push(tag, e, status);
  endtask

  task automatic b_start;
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic b_stop;
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_bus; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(ack);
  endtask

  task automatic rd_byte(output logic [7:0] d, input logic nack);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      recv_bit(b); d[i] = b;
    end
    send_bit(nack);
  endtask

  initial begin
    logic ack;
    logic [7:0] rb;
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    st("R1 status after reset", 32'h0);
    push("R1 sda_oe after reset", 32'h0, {31'h0, sda_oe});

    wr(3'd0, 32'h7);
    wr(3'd1, 32'h0000_513A);
    rd(3'd1, d); push("R3 own register readback", 32'h0000_513A, d);

    // primary address, write direction
    b_start();
    st("R2 busy after start", 32'h0002_0000);
    wr_byte(8'h74, ack);
    push("R6 ack on own1 match", 32'h0, {31'h0, ack});
    st("R3 own1 write match", 32'h0002_0002);
    rd(3'd3, d); rd(3'd4, d);
    st("R11 addr cleared by lo+hi read", 32'h0002_0000);
    wr_byte(8'hA5, ack);
    st("R7 rxne set, busy held", 32'h0002_0040);
    rd(3'd2, d); push("R7 received byte", 32'hA5, d);
    st("R7 rxne cleared by data read", 32'h0002_0000);
    b_stop();
    st("R2 stop clears busy, sets stopf", 32'h0000_0010);
    rd(3'd3, d); wr(3'd0, 32'h7);
    st("R12 stopf cleared by lo read + ctrl write", 32'h0);

    // second address, read direction
    wr(3'd2, 32'h3C);
    b_start();
    wr_byte(8'hA3, ack);
    push("R4 ack on own2 match", 32'h0, {31'h0, ack});
    st("R4 own2 read match", 32'h0086_0080);
    wr(3'd2, 32'hC3);
    st("R8 txe cleared by data write", 32'h0086_0000);
    rd_byte(rb, 1'b0); push("R8 first byte MSB first", 32'h3C, {24'h0, rb});
    st("R8 txe set at reload, no btf", 32'h0086_0080);
    rd_byte(rb, 1'b0); push("R8 second byte", 32'hC3, {24'h0, rb});
    st("R9 btf set on ack with txe", 32'h0086_0084);
    rd_byte(rb, 1'b1);
    st("R10 af on controller nack", 32'h0086_0484);
    push("R10 sda released after nack", 32'h0, {31'h0, sda_oe});
    b_stop();
    st("R2 stop clears busy and tra", 32'h0080_0494);
    rd(3'd3, d); rd(3'd4, d);
    st("R11 dual cleared", 32'h0000_0494);
    rd(3'd3, d); wr(3'd0, 32'h7);
    st("R10 af and stopf cleared by ctrl write", 32'h0000_0084);
    wr(3'd2, 32'h0);
    st("R9 btf cleared by data write", 32'h0);

    // general call enabled
    b_start();
    wr_byte(8'h00, ack);
    push("R5 ack on general call", 32'h0, {31'h0, ack});
    st("R5 general call flag", 32'h0012_0000);
    b_stop();
    rd(3'd3, d); rd(3'd4, d); rd(3'd3, d); wr(3'd0, 32'h5);
    st("R11 gc cleared", 32'h0);

    // general call disabled
    b_start();
    wr_byte(8'h00, ack);
    push("R5 no ack with gc disabled", 32'h1, {31'h0, ack});
    st("R5 no gc flag when disabled", 32'h0002_0000);
    b_stop();
    rd(3'd3, d); wr(3'd0, 32'h5);

    // address matching nothing
    b_start();
    wr_byte(8'h22, ack);
    push("R6 no ack on mismatch", 32'h1, {31'h0, ack});
    st("R6 no match flag on mismatch", 32'h0002_0000);
    b_stop();
    rd(3'd3, d); wr(3'd0, 32'h1);

    // dual addressing disabled
    b_start();
    wr_byte(8'hA2, ack);
    push("R4 own2 ignored when dual off", 32'h1, {31'h0, ack});
    b_stop();
    rd(3'd3, d); wr(3'd0, 32'h6);

    // acknowledge disabled
    b_start();
    wr_byte(8'h74, ack);
    push("R6 no ack when ack disabled", 32'h1, {31'h0, ack});
    st("R6 flag still set without ack", 32'h0002_0002);
    b_stop();
    st("R2 stop after unacked match", 32'h0000_0012);

    done = 1'b1;
    finish_run();
  end
endmodule